// File: doc/BRIEF.md
# Two-Digit Scanned Seven-Segment Display Driver

This block shows an unsigned value from 0 to 99 as two decimal digits on a bank of eight seven-segment positions. All positions share one segment bus. The block splits the value into a tens digit and a ones digit by comparing it against the decade boundaries. It encodes each digit as active-high segments and shows the two digits in turn, so that only one position is lit at any moment.

Only the two lowest positions of the eight-bit enable vector are scanned. A frame pacer built from a clock-enable counter sets how long each digit stays lit, and that frame length is a parameter. The value is captured once at the start of each tens frame. The following ones frame shows the same capture, so the two digits on the glass always belong to one number. A leading zero in the tens place is blanked, and any value above 99 blanks both digits.

Top module: `seg2_scan_display`

## Requirements
- R1: While reset is high, and after it is released until the first frame boundary, every enable bit and every segment line is 0. The first frame after reset is always the tens frame.
- R2: Segment bits are active-high, with bit 6 driving segment a and bit 0 driving segment g. The digit codes are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111 and 9=1110011.
- R3: When the captured value is below 10, the tens frame drives all segments to 0. A ones digit of 0 still shows the code for 0.
- R4: At most one enable bit is high at any time.
- R5: The tens frame drives enable 00000010 and the ones frame drives enable 00000001. Enable bits 7 to 2 are always 0.
- R6: Tens and ones frames alternate, and each frame holds its enable and segment values for exactly TICK_DIV clock cycles.
- R7: The value is sampled when a tens frame begins. The ones frame that follows shows the ones digit of that same sample, even if the input changes during the tens frame.
- R8: A sampled value above 99 drives both frames with all segments 0, while the enables keep scanning.
- R9: For every value from 0 to 99, the tens frame shows value/10 and the ones frame shows value mod 10, except where R3 blanks the tens digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| value_i | input | 8 | Binary value to display |
| seg_o | output | 7 | Shared segment bus, abcdefg, active-high |
| en_o | output | 8 | Digit-position enables, one-hot or all zero |

## Verification
The hardest case to reach is the one where the input changes between the tens frame and the ones frame of a single pair. The ones frame must then still show the earlier sample, and the only way to see this is to change the input in the middle of a tens frame. The driver waits until the scoreboard has consumed the tens item of a pair, then replaces the input with a different value for the rest of the pair. The scoreboard still expects the ones digit of the original value. The driver also sweeps every value from 0 to 99 and several values above 99. A reset in the middle of a run confirms that scanning restarts on the tens position.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam int SEG_W = 7;
  localparam int DIG_W = 4;

  typedef enum logic {
    PH_TENS = 1'b0,
    PH_ONES = 1'b1
  } phase_e;

  // Active-high abcdefg, a in bit 6.
  function automatic logic [SEG_W-1:0] digit_to_seg(input logic [DIG_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b0110000;
      4'd2:    s = 7'b1101101;
      4'd3:    s = 7'b1111001;
      4'd4:    s = 7'b0110011;
      4'd5:    s = 7'b1011011;
      4'd6:    s = 7'b0011111;
      4'd7:    s = 7'b1110000;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1110011;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/decade_split.sv
module decade_split #(
  parameter int VAL_W   = 8,
  parameter int DIG_W   = 4,
  parameter int MAX_VAL = 99
) (
  input  logic [VAL_W-1:0] value_i,
  output logic [DIG_W-1:0] tens_o,
  output logic [DIG_W-1:0] ones_o,
  output logic             in_range_o
);
  localparam int DECADES = MAX_VAL / 10;

  logic [DECADES-1:0] at_least;

  genvar k;
  generate
    for (k = 1; k <= DECADES; k++) begin : g_cmp
      assign at_least[k-1] = (value_i >= VAL_W'(k * 10));
    end
  endgenerate

  logic [VAL_W-1:0] tens_w;
  logic [VAL_W-1:0] rem_w;

  always_comb begin
    tens_w = '0;
    for (int i = 0; i < DECADES; i++) begin
      if (at_least[i]) tens_w = VAL_W'(i + 1);
    end
    rem_w      = value_i - VAL_W'(tens_w * VAL_W'(10));
    tens_o     = tens_w[DIG_W-1:0];
    ones_o     = rem_w[DIG_W-1:0];
    in_range_o = (value_i <= VAL_W'(MAX_VAL));
  end
endmodule

// File: rtl/digit_encoder.sv
module digit_encoder
  import disp_pkg::*;
#(
  parameter bit BLANK_ZERO = 1'b0
) (
  input  logic [DIG_W-1:0] digit_i,
  input  logic             blank_i,
  output logic [SEG_W-1:0] seg_o
);
  generate
    if (BLANK_ZERO) begin : g_lead_blank
      assign seg_o = (blank_i || (digit_i == '0)) ? '0 : digit_to_seg(digit_i);
    end else begin : g_plain
      assign seg_o = blank_i ? '0 : digit_to_seg(digit_i);
    end
  endgenerate
endmodule

// File: rtl/seg2_scan_display.sv
module seg2_scan_display
  import disp_pkg::*;
#(
  parameter int VAL_W    = 8,
  parameter int EN_W     = 8,
  parameter int MAX_VAL  = 99,
  parameter int TICK_DIV = 125000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] value_i,
  output logic [6:0]       seg_o,
  output logic [EN_W-1:0]  en_o
);
  localparam logic [EN_W-1:0] TENS_EN = EN_W'(2);
  localparam logic [EN_W-1:0] ONES_EN = EN_W'(1);
  localparam logic [EN_W-1:0] SCAN_MASK = TENS_EN | ONES_EN;

  logic             tick;
  phase_e           phase;
  logic [VAL_W-1:0] held;
  logic [VAL_W-1:0] src;
  logic [DIG_W-1:0] tens_d;
  logic [DIG_W-1:0] ones_d;
  logic             in_range;
  logic [SEG_W-1:0] seg_tens;
  logic [SEG_W-1:0] seg_ones;

  frame_pacer #(.DIV(TICK_DIV)) u_pacer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  // A tens frame takes a fresh sample; a ones frame reuses the held one.
  assign src = (phase == PH_TENS) ? value_i : held;

  decade_split #(.VAL_W(VAL_W), .DIG_W(DIG_W), .MAX_VAL(MAX_VAL)) u_split (
    .value_i    (src),
    .tens_o     (tens_d),
    .ones_o     (ones_d),
    .in_range_o (in_range)
  );

  digit_encoder #(.BLANK_ZERO(1'b1)) u_enc_tens (
    .digit_i (tens_d),
    .blank_i (!in_range),
    .seg_o   (seg_tens)
  );

  digit_encoder #(.BLANK_ZERO(1'b0)) u_enc_ones (
    .digit_i (ones_d),
    .blank_i (!in_range),
    .seg_o   (seg_ones)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_TENS;
      held  <= '0;
      seg_o <= '0;
      en_o  <= '0;
    end else if (tick) begin
      if (phase == PH_TENS) begin
        held  <= value_i;
        seg_o <= seg_tens;
        en_o  <= TENS_EN;
        phase <= PH_ONES;
      end else begin
        seg_o <= seg_ones;
        en_o  <= ONES_EN;
        phase <= PH_TENS;
      end
    end
  end

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_o)); // R4

  AST_UNUSED_POS: assert property (@(posedge clk) disable iff (rst)
    (en_o & ~SCAN_MASK) == '0); // R5

  AST_FRAME_SWITCH: assert property (@(posedge clk) disable iff (rst)
    tick |=> (en_o != $past(en_o))); // R6

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(en_o) && $stable(seg_o))); // R6

  AST_TENS_BLANK: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_TENS && value_i < VAL_W'(10)) |=> (seg_o == '0)); // R3

  AST_OVER_BLANK: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_TENS && value_i > VAL_W'(MAX_VAL)) |=> (seg_o == '0)); // R8

endmodule

// File: tb/seg2_scan_display_tb.sv
`timescale 1ns/1ps
module seg2_scan_display_tb;
  localparam int TB_DIV = 8;

  typedef struct {
    logic [6:0] seg;
    logic [7:0] en;
    int         val;
    string      req;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] value = 8'd0;
  logic [6:0] seg_o;
  logic [7:0] en_o;

  int checks  = 0;
  int fails   = 0;
  int pending = 0;
  bit done    = 1'b0;

  frame_t     exp_q[$];
  logic [7:0] prev_en = '0;
  int         gap = 0;

  always #2 clk = ~clk;

  seg2_scan_display #(.TICK_DIV(TB_DIV)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .value_i (value),
    .seg_o   (seg_o),
    .en_o    (en_o)
  );

  function automatic logic [6:0] seg_code(input int d);
    case (d)
      0: return 7'b1111110;
      1: return 7'b0110000;
      2: return 7'b1101101;
      3: return 7'b1111001;
      4: return 7'b0110011;
      5: return 7'b1011011;
      6: return 7'b0011111;
      7: return 7'b1110000;
      8: return 7'b1111111;
      9: return 7'b1110011;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: one scoreboard item per frame boundary.
  always @(negedge clk) begin
    if (rst) begin
      prev_en = '0;
      gap = 0;
    end else if (en_o !== prev_en) begin
      check("R4 single enable", 16'($countones(en_o) <= 1), 16'd1);
      if (prev_en != '0) check("R6 frame length", 16'(gap), 16'(TB_DIV - 1));
      if (exp_q.size() > 0) begin
        frame_t it;
        it = exp_q.pop_front();
        check({it.req, " R5 enable"}, {8'h00, en_o}, {8'h00, it.en});
        check({it.req, " segments"}, {9'h000, seg_o}, {9'h000, it.seg});
        pending--;
      end
      prev_en = en_o;
      gap = 0;
    end else begin
      gap++;
    end
  end

  function automatic frame_t exp_frame(input int v, input bit tens_pos, input string ones_req);
    frame_t f;
    f.val = v;
    if (tens_pos) begin
      f.en = 8'h02;
      if (v > 99)      begin f.seg = '0; f.req = "R8 tens"; end
      else if (v < 10) begin f.seg = '0; f.req = "R3 tens"; end
      else             begin f.seg = seg_code(v / 10); f.req = "R2 R9 tens"; end
    end else begin
      f.en = 8'h01;
      if (v > 99) begin f.seg = '0; f.req = "R8 ones"; end
      else        begin f.seg = seg_code(v % 10); f.req = ones_req; end
    end
    return f;
  endfunction

  // Driver: called during a ones frame; the next tens frame samples v.
  task automatic apply(input int v, input bit jumble, input int junk);
    value = 8'(v);
    exp_q.push_back(exp_frame(v, 1'b1, ""));
    exp_q.push_back(exp_frame(v, 1'b0, jumble ? "R7 ones" : "R2 R9 ones"));
    pending += 2;
    if (jumble) begin
      wait (pending == 1);
      #1 value = 8'(junk);
    end
    wait (pending == 0);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset enables", {8'h00, en_o}, 16'h0000);
    check("R1 reset segments", {9'h000, seg_o}, 16'h0000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle before first frame", {8'h00, en_o}, 16'h0000);
    while (en_o == '0) @(negedge clk);
    check("R1 first frame is tens", {8'h00, en_o}, 16'h0002);
    check("R3 zero tens blank", {9'h000, seg_o}, 16'h0000);
    while (en_o != 8'h01) @(negedge clk);
    check("R3 R2 zero ones shows 0", {9'h000, seg_o}, 16'h007E);
    #1;

    for (int v = 0; v <= 99; v++) apply(v, (v % 3) == 1, 99 - v);
    apply(100, 1'b0, 0);
    apply(37, 1'b1, 200);
    apply(150, 1'b0, 0);
    apply(255, 1'b1, 5);
    apply(40, 1'b0, 0);
    apply(81, 1'b1, 0);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset enables", {8'h00, en_o}, 16'h0000);
    check("R1 mid-run reset segments", {9'h000, seg_o}, 16'h0000);
    value = 8'd64;
    rst = 1'b0;
    while (en_o == '0) @(negedge clk);
    check("R1 restart on tens", {8'h00, en_o}, 16'h0002);
    check("R9 restart tens digit", {9'h000, seg_o}, {9'h000, seg_code(6)});
    finish_run();
  end
endmodule